// File: doc/BRIEF.md
# Sprite Line Evaluator

This block prepares the sprite layer of one video line at a time. A start pulse hands it a line number. It then reads the sprite attribute table from video memory through a simple read port. It picks out the 8x8 sprites whose rows cover that line and keeps up to four of them, in table order. It fetches one pattern byte for each kept sprite. It then emits one sprite pixel per clock for the 256 pixels of the line, and each pixel carries a colour and an opaque flag. The background merge downstream uses this stream.

While it scans and draws, the block keeps two sticky status flags and a latched table index. One flag records that a line had more matching sprites than it can show. The other records that set pattern bits of two sprites fell on the same pixel. The host clears both flags with a status-read pulse.

Top module: `sprite_line_eval`

## Requirements
- R1: After reset, busy, pix_valid, line_done, stat_fifth and stat_coll are 0 and stat_idx is 0.
- R2: Entry i of the table starts at byte address {attr_reg, 7'b0} + 4*i. Its bytes are, in order, the top Y, the left X, the pattern name and the colour (colour in bits 3:0). The pattern byte for row r is read at {pat_reg, 11'b0} + 8*name + r.
- R3: A sprite covers a line when row = (line - Y - 1) mod 256 is below 8. Y = 0xFF therefore puts row 0 on line 0, and any table entry including the last one can match.
- R4: An entry whose Y byte is 0xD0 ends the scan. Neither it nor any later entry is drawn or counted.
- R5: Entries are taken in ascending index order and at most four are kept per line. A fifth matching entry sets stat_fifth and ends the scan.
- R6: The index of the fifth matching entry is written to stat_idx only while stat_fifth is clear. Otherwise stat_idx holds its value.
- R7: Each accepted line produces exactly 256 pix_valid cycles, with pix_x running 0 to 255 on consecutive clocks. line_done is high in the cycle that carries pixel 255.
- R8: A kept sprite with left edge X covers pixel x when 0 <= x - X < 8, with no wrap past pixel 255. Pattern bit 7 - (x - X) is the pixel's bit, so bit 7 is the leftmost.
- R9: The pixel takes the colour of the lowest-index sprite whose bit is set and whose colour is non-zero, and pix_opaque is 1. A colour of 0 is transparent. With no such sprite, pix_opaque and pix_color are 0.
- R10: stat_coll is set when two or more kept sprites have set bits on the same pixel, whatever their colours.
- R11: stat_fifth and stat_coll stay set until a status_clr pulse, which clears both and leaves stat_idx unchanged. A set and a clear in the same cycle leave the flag set.
- R12: line_start is ignored while busy is high, and mem_rd stays low while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start evaluating line_num (taken only when idle) |
| line_num | input | 8 | Line to evaluate |
| attr_reg | input | 7 | Attribute table base, in units of 128 bytes |
| pat_reg | input | 3 | Sprite pattern base, in units of 2048 bytes |
| status_clr | input | 1 | Host status read: clears the sticky flags |
| mem_rd | output | 1 | Video memory read request |
| mem_addr | output | 14 | Video memory byte address |
| mem_data | input | 8 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Scan or draw in progress |
| pix_valid | output | 1 | Sprite pixel valid |
| pix_x | output | 8 | Pixel column |
| pix_color | output | 4 | Sprite colour, 0 when not opaque |
| pix_opaque | output | 1 | A sprite colours this pixel |
| line_done | output | 1 | Last pixel of the line |
| stat_fifth | output | 1 | Too many sprites on a line (sticky) |
| stat_coll | output | 1 | Sprite pixel collision (sticky) |
| stat_idx | output | 5 | Index of the fifth matching entry |

## Verification
The scan is driven with several table layouts. One has a single sprite at the Y = 0xFF wrap point, read on different rows. One has a terminator placed ahead of a visible entry. One has five or more matches on a line, with the first matches at different positions. One has no terminator, so all 32 entries are walked and only the last one matches. These separate row arithmetic, the stop rule, the slot limit and the table bounds. The draw stage is exercised with overlapping sprites that include a transparent colour, which shows whether priority and collision are handled apart, and with a sprite at the right edge, which shows whether it is clipped or wraps. Repeated fifth-sprite lines with and without a status clear in between show whether the index is latched or refreshed. A second pair of base values confirms the address formation. A start pulse sent mid-line shows that the pulse is ignored.

// File: rtl/sprite_line_eval.sv
module sprite_line_eval #(
  parameter int          MAX_SLOTS   = 4,
  parameter int          NUM_ENTRIES = 32,
  parameter logic [7:0]  STOP_Y      = 8'hD0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic [7:0]  line_num,
  input  logic [6:0]  attr_reg,
  input  logic [2:0]  pat_reg,
  input  logic        status_clr,
  output logic        mem_rd,
  output logic [13:0] mem_addr,
  input  logic [7:0]  mem_data,
  output logic        busy,
  output logic        pix_valid,
  output logic [7:0]  pix_x,
  output logic [3:0]  pix_color,
  output logic        pix_opaque,
  output logic        line_done,
  output logic        stat_fifth,
  output logic        stat_coll,
  output logic [4:0]  stat_idx
);
  localparam int IW = $clog2(NUM_ENTRIES);
  localparam int CW = $clog2(MAX_SLOTS + 1);
  localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_YRQ, S_YCK, S_FRQ, S_FCK, S_DRAW, S_DONE} st_t;

  st_t            st;
  logic [7:0]     line_q;
  logic [IW-1:0]  idx;
  logic [CW-1:0]  cnt;
  logic [1:0]     ph;
  logic [2:0]     row;
  logic [7:0]     name_q;
  logic [7:0]     x;
  logic [7:0]     sx [MAX_SLOTS];
  logic [3:0]     sc [MAX_SLOTS];
  logic [7:0]     sp [MAX_SLOTS];

  logic [7:0]  dy;
  logic        is_stop, is_match, is_last, is_full, fifth_set;
  logic [SW-1:0] slot;
  logic [13:0] entry_addr;

  assign dy        = line_q - mem_data - 8'd1;
  assign is_stop   = (mem_data == STOP_Y);
  assign is_match  = (dy < 8'd8);
  assign is_last   = (idx == IW'(NUM_ENTRIES - 1));
  assign is_full   = (cnt == CW'(MAX_SLOTS));
  assign fifth_set = (st == S_YCK) && !is_stop && is_match && is_full;
  assign slot      = cnt[SW-1:0];

  assign entry_addr = {attr_reg, 7'b0} + 14'({idx, 2'b00});
  assign mem_rd     = (st == S_YRQ) || (st == S_FRQ);
  assign mem_addr   = (st == S_FRQ && ph == 2'd3) ? {pat_reg, name_q, row}
                    : (st == S_FRQ) ? entry_addr + 14'(ph) + 14'd1
                    : entry_addr;
  assign busy       = (st != S_IDLE);
  assign line_done  = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      line_q <= '0;
      idx    <= '0;
      cnt    <= '0;
      ph     <= '0;
      row    <= '0;
      name_q <= '0;
      x      <= '0;
      for (int s = 0; s < MAX_SLOTS; s++) begin
        sx[s] <= '0;
        sc[s] <= '0;
        sp[s] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (line_start) begin
          line_q <= line_num;
          idx    <= '0;
          cnt    <= '0;
          st     <= S_YRQ;
        end
        S_YRQ: st <= S_YCK;
        S_YCK: begin
          if (is_stop || (is_match && is_full)) begin
            x  <= '0;
            st <= S_DRAW;
          end else if (is_match) begin
            row <= dy[2:0];
            ph  <= '0;
            st  <= S_FRQ;
          end else if (is_last) begin
            x  <= '0;
            st <= S_DRAW;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_YRQ;
          end
        end
        S_FRQ: st <= S_FCK;
        S_FCK: begin
          case (ph)
            2'd0: sx[slot] <= mem_data;
            2'd1: name_q   <= mem_data;
            2'd2: sc[slot] <= mem_data[3:0];
            default: sp[slot] <= mem_data;
          endcase
          if (ph == 2'd3) begin
            cnt <= cnt + 1'b1;
            if (is_last) begin
              x  <= '0;
              st <= S_DRAW;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_YRQ;
            end
          end else begin
            ph <= ph + 1'b1;
            st <= S_FRQ;
          end
        end
        S_DRAW: begin
          x <= x + 1'b1;
          if (x == 8'hFF) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [MAX_SLOTS-1:0] hit;
  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    logic [8:0] d;
    assign d      = {1'b0, x} - {1'b0, sx[s]};
    assign hit[s] = (CW'(s) < cnt) && (d < 9'd8) && sp[s][3'd7 - d[2:0]];
  end

  logic [3:0] win_c;
  logic       win_o;
  logic [CW-1:0] nhit;
  always_comb begin
    win_c = '0;
    win_o = 1'b0;
    nhit  = '0;
    for (int s = MAX_SLOTS - 1; s >= 0; s--) begin
      if (hit[s]) nhit = nhit + 1'b1;
      if (hit[s] && sc[s] != 4'd0) begin
        win_c = sc[s];
        win_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid  <= 1'b0;
      pix_x      <= '0;
      pix_color  <= '0;
      pix_opaque <= 1'b0;
    end else begin
      pix_valid  <= (st == S_DRAW);
      pix_x      <= x;
      pix_color  <= win_c;
      pix_opaque <= win_o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_fifth <= 1'b0;
      stat_coll  <= 1'b0;
      stat_idx   <= '0;
    end else begin
      if (status_clr) begin
        stat_fifth <= 1'b0;
        stat_coll  <= 1'b0;
      end
      if (fifth_set) begin
        stat_fifth <= 1'b1;
        if (!stat_fifth) stat_idx <= 5'(idx);
      end
      if (st == S_DRAW && nhit > CW'(1)) stat_coll <= 1'b1;
    end
  end
endmodule

module sprite_line_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        status_clr,
  input logic        mem_rd,
  input logic        busy,
  input logic        pix_valid,
  input logic [7:0]  pix_x,
  input logic [3:0]  pix_color,
  input logic        pix_opaque,
  input logic        line_done,
  input logic        stat_fifth,
  input logic        stat_coll,
  input logic [4:0]  stat_idx
);
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_rd); // R12
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_x != 8'hFF) |=> (pix_valid && pix_x == 8'($past(pix_x) + 8'd1))); // R7
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (pix_valid && pix_x == 8'hFF)); // R7
  AST_OPAQUE_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_opaque) |-> (pix_color != 4'd0)); // R9
  AST_FIFTH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_fifth && !status_clr) |=> stat_fifth); // R11
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_coll && !status_clr) |=> stat_coll); // R11
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fifth |=> $stable(stat_idx)); // R6
  AST_PIX_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> busy); // R7
endmodule

bind sprite_line_eval sprite_line_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_clr(status_clr), .mem_rd(mem_rd), .busy(busy),
  .pix_valid(pix_valid), .pix_x(pix_x), .pix_color(pix_color), .pix_opaque(pix_opaque),
  .line_done(line_done), .stat_fifth(stat_fifth), .stat_coll(stat_coll), .stat_idx(stat_idx)
);

// File: tb/tb_sprite_line_eval.sv
module tb_sprite_line_eval;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        line_start = 0;
  logic [7:0]  line_num = 0;
  logic [6:0]  attr_reg = 7'h76;
  logic [2:0]  pat_reg = 3'h3;
  logic        status_clr = 0;
  logic        mem_rd;
  logic [13:0] mem_addr;
  logic [7:0]  mem_data = 0;
  logic        busy, pix_valid, pix_opaque, line_done, stat_fifth, stat_coll;
  logic [7:0]  pix_x;
  logic [3:0]  pix_color;
  logic [4:0]  stat_idx;

  sprite_line_eval dut (.*);

  always #5 clk = ~clk;

  logic [7:0] mem [int];
  int nchk = 0, nfail = 0;
  bit finished = 0;
  string cur_tag = "R1";
  logic [12:0] expq [$];
  bit   exp_fifth = 0, exp_coll = 0;
  logic [4:0] exp_idx = 0;

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= rd(int'(mem_addr));

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n && pix_valid) begin
    if (expq.size() == 0) chk(cur_tag, "unexpected pixel", 1, 0);
    else begin
      logic [12:0] e;
      e = expq.pop_front();
      chk(cur_tag, "pixel x/color/opaque", {pix_x, pix_color, pix_opaque}, e);
    end
  end

  function automatic int ab(); return int'(attr_reg) * 128; endfunction
  function automatic int pb(); return int'(pat_reg) * 2048; endfunction

  task automatic put_spr(int i, logic [7:0] y, logic [7:0] xx, logic [7:0] n, logic [7:0] c);
    mem[ab() + 4*i]     = y;
    mem[ab() + 4*i + 1] = xx;
    mem[ab() + 4*i + 2] = n;
    mem[ab() + 4*i + 3] = c;
  endtask

  task automatic fill_y(logic [7:0] y);
    for (int i = 0; i < 32; i++) put_spr(i, y, 0, 0, 0);
  endtask

  task automatic set_pat(logic [7:0] n, int r, logic [7:0] v);
    mem[pb() + 8*n + r] = v;
  endtask

  task automatic model_line(logic [7:0] ln);
    int cnt;
    logic [7:0] kx [4];
    logic [3:0] kc [4];
    logic [7:0] kp [4];
    cnt = 0;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] y, r;
      y = rd(ab() + 4*i);
      if (y == 8'hD0) break;
      r = ln - y - 8'd1;
      if (r < 8) begin
        if (cnt == 4) begin
          if (!exp_fifth) exp_idx = 5'(i);
          exp_fifth = 1;
          break;
        end
        kx[cnt] = rd(ab() + 4*i + 1);
        kc[cnt] = rd(ab() + 4*i + 3) & 8'h0F;
        kp[cnt] = rd(pb() + 8*rd(ab() + 4*i + 2) + r);
        cnt++;
      end
    end
    for (int xx = 0; xx < 256; xx++) begin
      int nh;
      logic [3:0] c;
      logic o;
      nh = 0; c = 0; o = 0;
      for (int s = 0; s < cnt; s++) begin
        int d;
        d = xx - int'(kx[s]);
        if (d >= 0 && d < 8 && kp[s][7-d]) begin
          nh++;
          if (!o && kc[s] != 0) begin o = 1; c = kc[s]; end
        end
      end
      if (nh > 1) exp_coll = 1;
      expq.push_back({8'(xx), c, o});
    end
  endtask

  task automatic check_status(string rq);
    chk(rq, "stat_fifth", stat_fifth, exp_fifth);
    chk(rq, "stat_coll", stat_coll, exp_coll);
    chk(rq, "stat_idx", stat_idx, exp_idx);
  endtask

  task automatic run_line(string rq, logic [7:0] ln, bit disturb);
    cur_tag = rq;
    model_line(ln);
    @(negedge clk); line_start = 1; line_num = ln;
    @(negedge clk); line_start = 0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      line_start = 1; line_num = ln + 8'd3;
      @(negedge clk); line_start = 0;
    end
    do @(negedge clk); while (!line_done);
    check_status(rq);
    @(negedge clk);
    chk(rq, "pixels left unchecked", expq.size(), 0);
    chk(rq, "busy after line", busy, 0);
  endtask

  task automatic clear_status();
    @(negedge clk); status_clr = 1;
    @(negedge clk); status_clr = 0;
    exp_fifth = 0; exp_coll = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R7 watchdog: actual hung expected line completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "pix_valid", pix_valid, 0);
    chk("R1", "line_done", line_done, 0);
    check_status("R1");

    // R3 R8: single sprite at the Y wrap point, rows 0, 3, 7 and just below
    fill_y(8'hD0);
    put_spr(0, 8'hFF, 8'd0, 8'd1, 8'hAF);
    set_pat(1, 0, 8'hF0); set_pat(1, 3, 8'hA5); set_pat(1, 7, 8'h81);
    run_line("R3", 8'd0, 0);
    run_line("R8", 8'd3, 0);
    run_line("R3", 8'd7, 0);
    run_line("R3", 8'd8, 0);

    // R4: terminator ahead of a visible entry
    put_spr(0, 8'hD0, 0, 1, 15);
    put_spr(1, 8'hFF, 8'd20, 8'd1, 8'd9);
    run_line("R4", 8'd0, 0);

    // R5 R6: six matches, fifth at index 4
    fill_y(8'hD0);
    set_pat(2, 0, 8'hFF);
    for (int i = 0; i < 6; i++) put_spr(i, 8'd19, 8'(i*16), 8'd2, 8'(i+2));
    run_line("R5", 8'd20, 0);
    // fifth now at index 6, flag still set: index must hold
    put_spr(0, 8'd100, 0, 2, 3); put_spr(1, 8'd100, 0, 2, 3);
    put_spr(6, 8'd19, 8'd96, 8'd2, 8'd8); put_spr(7, 8'd19, 8'd112, 8'd2, 8'd9);
    run_line("R6", 8'd20, 0);
    clear_status();
    @(negedge clk);
    check_status("R11");
    run_line("R6", 8'd20, 0);

    // R9 R10: overlap with a transparent top-priority sprite
    clear_status();
    fill_y(8'hD0);
    set_pat(3, 0, 8'hFF);
    put_spr(0, 8'd39, 8'd10, 8'd3, 8'h00);
    put_spr(1, 8'd39, 8'd12, 8'd3, 8'h0E);
    put_spr(2, 8'd39, 8'd14, 8'd3, 8'h03);
    run_line("R9", 8'd40, 0);
    chk("R10", "collision", stat_coll, 1);
    clear_status();
    @(negedge clk);
    check_status("R11");

    // R8: right-edge clipping, no wrap
    fill_y(8'hD0);
    put_spr(0, 8'd49, 8'd252, 8'd3, 8'h05);
    run_line("R8", 8'd50, 0);

    // R2: other base values
    attr_reg = 7'h10; pat_reg = 3'h2;
    fill_y(8'hD0);
    set_pat(4, 5, 8'h3C);
    put_spr(0, 8'd59, 8'd100, 8'd4, 8'hC7);
    run_line("R2", 8'd65, 0);

    // R3: no terminator, only the last entry matches
    fill_y(8'd200);
    put_spr(31, 8'd69, 8'd30, 8'd4, 8'h06);
    run_line("R3", 8'd75, 0);

    // R12: start pulse during a busy line is ignored
    run_line("R12", 8'd75, 1);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule